// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-word SPI master controlled through a small memory-mapped register window. Software writes up to 32 bits of transmit data into a four-entry transmit queue. It then writes the command register with the word length, clock mode, chip-select number and direction enables, and sets the start bit. The shift engine clocks the word out most-significant-bit first. It captures the returning bits and places the right-aligned received word into a four-entry receive queue. When it finishes, it raises a ready flag that stays set until software writes one to it.

Chip select is active low. In hardware control, the selected line is asserted only while a transfer runs. In software control, the selected line follows a level bit held in the command register. Queue misuse raises sticky flags that software clears by writing one: a push into a full transmit queue, a start with an empty transmit queue, a completion into a full receive queue, or a pop from an empty receive queue. Each of these also raises a sticky error summary flag. The serial clock is the system clock divided by `2*HALF_DIV`.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, every chip-select line is high and `sck_o` is low. The command register (offset 0x000) reads 0, the transfer status register (0x010) reads 0, and the queue status register (0x014) reads 0x5, meaning both queues are empty.
- R2: A write to 0x000 with bit 31 set starts a transfer. The transfer pops the transmit queue head (pushed at 0x108) if bit 11 is set, and shifts out the low (bits[4:0]+1) bits of that word, most significant bit first.
- R3: If bit 12 of the command register is set, the sampled bits are pushed at completion as a right-aligned word, with the first received bit in the most significant used position. The word is read, and popped, at 0x188.
- R4: Command bit 29 is the clock idle level and bit 28 the phase. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, the edges swap roles. Between transfers, `sck_o` equals bit 29.
- R5: Bit 30 of 0x010 sets when a transfer completes. It stays set until a write to 0x010 with bit 30 set clears it.
- R6: With bit 21 clear, the chip select chosen by bits 27:26 goes low only while the transfer runs. All lines are high before and after.
- R7: With bit 21 set, the chosen chip select equals bit 20 and the others stay high.
- R8: In 0x014, bit 3 shows a full transmit queue and bit 2 an empty one. A push into the full queue drops the word and sets bit 7 and bit 8.
- R9: A read of 0x188 with an empty receive queue returns 0 and sets bit 4 and bit 8 of 0x014. Bit 0 shows an empty receive queue.
- R10: A completion with a full receive queue (bit 1 of 0x014) drops the word and sets bit 5 and bit 8.
- R11: A start with bit 11 set and an empty transmit queue sets bit 6 and bit 8, and shifts out zeros.
- R12: Bits 8:4 of 0x014 are sticky. Writing one clears the written bits, and writing zero leaves them unchanged.
- R13: While a transfer is pending or running, bit 31 of 0x000 reads 1, and any write to 0x000 is ignored, including its start bit and every field.
- R14: With bit 11 clear, the transmit queue is not popped and `mosi_o` stays low. With bit 12 clear, nothing is pushed into the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 10 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Active-low chip selects |

## Verification
A wrong edge counter or phase state shows up at the slave model within the first serial clock period. It appears as a shifted or doubled bit, or as `sck_o` left at the wrong idle level once the transfer ends. A queue pointer or count error surfaces at the next status read or receive pop, where the flags and the data order are compared against an independent model. A start-gating fault becomes visible as soon as a command write lands during a busy transfer: the read-back fields change, or a second completion appears in the transfer status register.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int NUM_CS = 4;

  localparam logic [9:0] OFS_CMD  = 10'h000;
  localparam logic [9:0] OFS_XSTS = 10'h010;
  localparam logic [9:0] OFS_FSTS = 10'h014;
  localparam logic [9:0] OFS_TXP  = 10'h108;
  localparam logic [9:0] OFS_RXP  = 10'h188;

  localparam int B_GO    = 31;
  localparam int B_READY = 30;

  typedef struct packed {
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] cs_sel;
    logic       cs_sw;
    logic       cs_lvl;
    logic       rx_en;
    logic       tx_en;
    logic [4:0] len_m1;
  } cmd_t;

  typedef struct packed {
    logic err;
    logic tx_ovf;
    logic tx_unr;
    logic rx_ovf;
    logic rx_unr;
  } sticky_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  wire do_push = push_i && !full_o;
  wire do_pop  = pop_i && !empty_o;

  assign full_o  = cnt_q == (AW+1)'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign head_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // a dropped push must not change occupancy
  assert_full_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o)
    else $error("full queue lost occupancy on dropped push");
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        cpol_i,
  input  logic        cpha_i,
  input  logic [4:0]  len_i,
  input  logic [31:0] tx_word_i,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] rx_word_o,
  output logic        sck_o,
  output logic        mosi_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          run_q, ph_q;
  logic [CW-1:0] div_q;
  logic [6:0]    edge_q;
  logic [31:0]   tx_sr_q, rx_sr_q;

  wire       tick      = run_q && (div_q == CW'(HALF_DIV-1));
  wire [6:0] last_edge = {1'b0, len_i, 1'b0} + 7'd2;
  wire       fin       = tick && (edge_q == last_edge);
  wire       smp_edge  = tick && !fin && (edge_q[0] == cpha_i);
  // first launch is preloaded at start, so phase-1 skips edge 0
  wire       sh_edge   = tick && !fin && (edge_q[0] != cpha_i) && (edge_q != 7'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ph_q    <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      ph_q    <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      tx_sr_q <= tx_word_i << (5'd31 - len_i);
      rx_sr_q <= '0;
    end else if (run_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (fin) run_q <= 1'b0;
        else begin
          edge_q <= edge_q + 7'd1;
          ph_q   <= ~ph_q;
        end
      end
      if (smp_edge) rx_sr_q <= {rx_sr_q[30:0], miso_i};
      if (sh_edge)  tx_sr_q <= {tx_sr_q[30:0], 1'b0};
    end
  end

  assign busy_o    = run_q;
  assign done_o    = fin;
  assign rx_word_o = rx_sr_q;
  assign sck_o     = cpol_i ^ ph_q;
  assign mosi_o    = run_q && tx_sr_q[31];

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (sck_o == cpol_i))
    else $error("serial clock not at idle level");
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_ctl_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int Q_DEPTH  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_valid_i,
  input  logic                reg_write_i,
  input  logic [9:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic [NUM_CS-1:0]   cs_no
);
  cmd_t    cmd_q;
  sticky_t stk_q;
  logic    start_q, ready_q;
  logic    eng_busy, eng_done;
  logic [31:0] eng_rx, tx_head, rx_head;
  logic    tx_full, tx_empty, rx_full, rx_empty;

  wire wr      = reg_valid_i && reg_write_i;
  wire rd      = reg_valid_i && !reg_write_i;
  wire cmd_wr  = wr && (reg_addr_i == OFS_CMD);
  wire xsts_wr = wr && (reg_addr_i == OFS_XSTS);
  wire fsts_wr = wr && (reg_addr_i == OFS_FSTS);
  wire busy    = start_q || eng_busy;

  wire tx_push = wr && (reg_addr_i == OFS_TXP);
  wire tx_pop  = start_q && cmd_q.tx_en;
  wire rx_push = eng_done && cmd_q.rx_en;
  wire rx_pop  = rd && (reg_addr_i == OFS_RXP);

  wire ev_tx_ovf = tx_push && tx_full;
  wire ev_tx_unr = tx_pop && tx_empty;
  wire ev_rx_ovf = rx_push && rx_full;
  wire ev_rx_unr = rx_pop && rx_empty;
  wire ev_any    = ev_tx_ovf || ev_tx_unr || ev_rx_ovf || ev_rx_unr;

  wire [31:0] tx_word = (cmd_q.tx_en && !tx_empty) ? tx_head : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
      ready_q <= 1'b0;
      stk_q   <= '0;
    end else begin
      // whole command write is dropped while a transfer is pending or running
      if (cmd_wr && !busy)
        cmd_q <= '{master: reg_wdata_i[30], cpol: reg_wdata_i[29], cpha: reg_wdata_i[28],
                   cs_sel: reg_wdata_i[27:26], cs_sw: reg_wdata_i[21], cs_lvl: reg_wdata_i[20],
                   rx_en: reg_wdata_i[12], tx_en: reg_wdata_i[11], len_m1: reg_wdata_i[4:0]};
      start_q <= cmd_wr && reg_wdata_i[B_GO] && !busy;
      // set wins over a same-cycle clear
      ready_q <= eng_done || (ready_q && !(xsts_wr && reg_wdata_i[B_READY]));
      stk_q.err    <= ev_any    || (stk_q.err    && !(fsts_wr && reg_wdata_i[8]));
      stk_q.tx_ovf <= ev_tx_ovf || (stk_q.tx_ovf && !(fsts_wr && reg_wdata_i[7]));
      stk_q.tx_unr <= ev_tx_unr || (stk_q.tx_unr && !(fsts_wr && reg_wdata_i[6]));
      stk_q.rx_ovf <= ev_rx_ovf || (stk_q.rx_ovf && !(fsts_wr && reg_wdata_i[5]));
      stk_q.rx_unr <= ev_rx_unr || (stk_q.rx_unr && !(fsts_wr && reg_wdata_i[4]));
    end
  end

  spi_word_fifo #(.W(32), .DEPTH(Q_DEPTH)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(reg_wdata_i), .pop_i(tx_pop),
    .head_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  spi_word_fifo #(.W(32), .DEPTH(Q_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(eng_rx), .pop_i(rx_pop),
    .head_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  spi_shift_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk_i, .rst_ni, .start_i(start_q), .cpol_i(cmd_q.cpol), .cpha_i(cmd_q.cpha),
    .len_i(cmd_q.len_m1), .tx_word_i(tx_word), .miso_i, .busy_o(eng_busy),
    .done_o(eng_done), .rx_word_o(eng_rx), .sck_o, .mosi_o);

  always_comb begin
    unique case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = {busy, cmd_q.master, cmd_q.cpol, cmd_q.cpha, cmd_q.cs_sel,
                               4'b0, cmd_q.cs_sw, cmd_q.cs_lvl, 7'b0, cmd_q.rx_en,
                               cmd_q.tx_en, 6'b0, cmd_q.len_m1};
      OFS_XSTS: reg_rdata_o = {1'b0, ready_q, 30'b0};
      OFS_FSTS: reg_rdata_o = {23'b0, stk_q.err, stk_q.tx_ovf, stk_q.tx_unr, stk_q.rx_ovf,
                               stk_q.rx_unr, tx_full, tx_empty, rx_full, rx_empty};
      OFS_RXP:  reg_rdata_o = rx_empty ? 32'h0 : rx_head;
      default:  reg_rdata_o = 32'h0;
    endcase
  end

  wire cs_on = cmd_q.cs_sw ? !cmd_q.cs_lvl : eng_busy;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(cs_on && (cmd_q.cs_sel == 2'(g)));
  end

  assert_cmd_locked_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_wr) |=> $stable(cmd_q))
    else $error("command changed during transfer");

  assert_ready_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> ready_q)
    else $error("ready flag missing after completion");

  assert_err_summary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_any |=> stk_q.err)
    else $error("error summary not raised");

  assert_hw_cs_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && !cmd_q.cs_sw) |-> ($countones(~cs_no) == 1))
    else $error("hardware chip select not unique during transfer");
endmodule

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, miso = 1'b0;
  logic [3:0]  cs_n;

  int total = 0, fails = 0;

  always #4 clk = ~clk;

  spi_reg_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(write),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n));

  // slave model
  logic        s_cpol = 0, s_cpha = 0, s_first = 0;
  int          s_len = 8, s_bit = 0;
  logic [31:0] s_tx = '0, s_rx = '0;
  wire         cs_act = (cs_n != 4'hF);

  always @(posedge cs_act) begin
    s_rx = '0; s_bit = s_len - 1; s_first = 1;
    miso = (s_bit >= 0) ? s_tx[s_bit] : 1'b0;
  end

  always @(sck) if (cs_act) begin
    if ((sck != s_cpol) != s_cpha) s_rx = {s_rx[30:0], mosi};
    else if (s_cpha && s_first) s_first = 0;
    else begin
      s_bit = s_bit - 1;
      miso = (s_bit >= 0) ? s_tx[s_bit] : 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); valid = 0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic go, input logic [1:0] mode,
      input logic [1:0] sel, input logic sw, input logic lvl, input logic rx,
      input logic tx, input logic [4:0] lm1);
    return {go, 1'b1, mode, sel, 4'b0, sw, lvl, 7'b0, rx, tx, 6'b0, lm1};
  endfunction

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic wait_ready(input string req);
    logic [31:0] v;
    for (int i = 0; i < 1000; i++) begin
      rd(10'h010, v);
      if (v[30]) return;
    end
    chk(req, 32'h0, 32'h4000_0000);
  endtask

  task automatic clear_all();
    wr(10'h014, 32'h1F0);
    wr(10'h010, 32'h4000_0000);
  endtask

  task automatic go(input logic [1:0] mode, input int n, input logic [1:0] sel,
      input logic rx, input logic tx, input logic [31:0] stx);
    s_cpol = mode[1]; s_cpha = mode[0]; s_len = n; s_tx = stx;
    wr(10'h000, mk_cmd(1, mode, sel, 0, 0, rx, tx, 5'(n-1)));
    wait_ready("R5 wait");
    wr(10'h010, 32'h4000_0000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs", {28'h0, cs_n}, 32'hF);
    chk("R1 sck", {31'h0, sck}, 32'h0);
    rd(10'h000, v); chk("R1 cmd", v, 32'h0);
    rd(10'h010, v); chk("R1 xsts", v, 32'h0);
    rd(10'h014, v); chk("R1 fsts", v, 32'h5);
  endtask

  task automatic t_xfer(input logic [1:0] mode, input int n, input logic [31:0] txw,
      input logic [31:0] stx, input logic [1:0] sel);
    logic [31:0] v;
    wr(10'h108, txw);
    wr(10'h000, mk_cmd(0, mode, sel, 0, 0, 1, 1, 5'(n-1)));
    chk("R4 idle before", {31'h0, sck}, {31'h0, mode[1]});
    s_cpol = mode[1]; s_cpha = mode[0]; s_len = n; s_tx = stx;
    wr(10'h000, mk_cmd(1, mode, sel, 0, 0, 1, 1, 5'(n-1)));
    repeat (3) @(negedge clk);
    chk("R6 cs during", {28'h0, cs_n}, {28'h0, ~(4'b1 << sel)});
    wait_ready("R5 ready");
    chk("R6 cs after", {28'h0, cs_n}, 32'hF);
    chk("R4 idle after", {31'h0, sck}, {31'h0, mode[1]});
    chk("R2 slave got", s_rx, txw & msk(n));
    rd(10'h188, v); chk("R3 rx word", v, stx & msk(n));
    wr(10'h010, 32'h4000_0000);
    rd(10'h010, v); chk("R5 ready cleared", v, 32'h0);
  endtask

  task automatic t_sw_cs();
    wr(10'h000, mk_cmd(0, 2'd0, 2'd2, 1, 0, 0, 0, 5'd7));
    chk("R7 sw low", {28'h0, cs_n}, 32'hB);
    wr(10'h000, mk_cmd(0, 2'd0, 2'd2, 1, 1, 0, 0, 5'd7));
    chk("R7 sw high", {28'h0, cs_n}, 32'hF);
  endtask

  task automatic t_tx_ovf();
    logic [31:0] v;
    clear_all();
    for (int i = 1; i <= 4; i++) wr(10'h108, 32'h11 * i);
    rd(10'h014, v); chk("R8 full", v, 32'h9);
    wr(10'h108, 32'h55);
    rd(10'h014, v); chk("R8 overflow", v, 32'h189);
    wr(10'h014, 32'h80);
    rd(10'h014, v); chk("R12 clear ovf only", v, 32'h109);
    wr(10'h014, 32'h0);
    rd(10'h014, v); chk("R12 zero write", v, 32'h109);
    wr(10'h014, 32'h100);
    rd(10'h014, v); chk("R12 clear err", v, 32'h9);
    for (int i = 1; i <= 4; i++) begin
      go(2'd0, 8, 2'd0, 0, 1, 32'h0);
      chk("R8 drained word", s_rx, 32'h11 * i);
    end
    rd(10'h014, v); chk("R14 rx not pushed", v, 32'h5);
  endtask

  task automatic t_rx_unr();
    logic [31:0] v;
    clear_all();
    rd(10'h188, v); chk("R9 empty read", v, 32'h0);
    rd(10'h014, v); chk("R9 flags", v, 32'h115);
    wr(10'h014, 32'h110);
    rd(10'h014, v); chk("R12 clear unr", v, 32'h5);
  endtask

  task automatic t_rx_ovf();
    logic [31:0] v;
    clear_all();
    for (int i = 1; i <= 5; i++) begin
      go(2'd0, 8, 2'd1, 1, 0, 32'hA0 + i);
      chk("R14 mosi low", s_rx, 32'h0);
      if (i == 4) begin rd(10'h014, v); chk("R10 rx full", v, 32'h6); end
    end
    rd(10'h014, v); chk("R10 overflow", v, 32'h126);
    for (int i = 1; i <= 4; i++) begin
      rd(10'h188, v); chk("R10 kept word", v, 32'hA0 + i);
    end
    wr(10'h014, 32'h120);
    rd(10'h014, v); chk("R12 clear rx ovf", v, 32'h5);
  endtask

  task automatic t_tx_unr();
    logic [31:0] v;
    clear_all();
    go(2'd0, 8, 2'd0, 1, 1, 32'h3C);
    chk("R11 zeros sent", s_rx, 32'h0);
    rd(10'h014, v); chk("R11 flags", v, 32'h144);
    rd(10'h188, v); chk("R11 rx word", v, 32'h3C);
    clear_all();
  endtask

  task automatic t_busy();
    logic [31:0] v;
    clear_all();
    s_cpol = 0; s_cpha = 0; s_len = 32; s_tx = 32'h1234_5678;
    wr(10'h108, 32'hDEAD_BEEF);
    wr(10'h000, mk_cmd(1, 2'd0, 2'd0, 0, 0, 1, 1, 5'd31));
    rd(10'h000, v); chk("R13 busy bit", {31'h0, v[31]}, 32'h1);
    wr(10'h000, mk_cmd(1, 2'd3, 2'd1, 0, 0, 1, 1, 5'd7));
    rd(10'h000, v); chk("R13 fields kept", {v[29:26], 23'h0, v[4:0]}, {4'h0, 23'h0, 5'd31});
    wait_ready("R13 ready");
    wr(10'h010, 32'h4000_0000);
    repeat (200) @(negedge clk);
    rd(10'h010, v); chk("R13 no second run", v, 32'h0);
    chk("R2 32-bit slave", s_rx, 32'hDEAD_BEEF);
    rd(10'h188, v); chk("R3 32-bit rx", v, 32'h1234_5678);
    rd(10'h014, v); chk("R13 single word", v, 32'h5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_xfer(2'd0, 8, 32'h5A, 32'hC3, 2'd1);
    t_xfer(2'd1, 16, 32'hBEEF, 32'h1234, 2'd2);
    t_xfer(2'd2, 32, 32'hCAFE_F00D, 32'h8765_4321, 2'd3);
    t_xfer(2'd3, 12, 32'hABC, 32'h5A5, 2'd0);
    t_sw_cs();
    t_tx_ovf();
    t_rx_unr();
    t_rx_ovf();
    t_tx_unr();
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule